// File: doc/BRIEF.md
# Packed-Sample DAC Data FIFO

This block is the sample buffer in front of a current-output DAC. Software or a DMA engine writes 32-bit words into a data register. The block splits each word into one or more samples according to a 2-bit format field, justifies each sample, and stores it in a four-slot FIFO of 16-bit entries. Each pulse on the update strobe moves the next sample onto the registered DAC code output.

Three sticky flags record FIFO events: a write that does not fit (overrun), an update with nothing to send (underrun), and an update that drains the last entry (went empty). Each flag drives the interrupt line only when its enable bit is set. Software clears a flag by writing 0 to it and forces it by writing 1. A wrap mode replays the stored samples in a loop instead of consuming them. A self-clearing control bit empties the buffer. The stored slots can also be read back directly through a small word-addressed register port.

Top module: `dac_sample_fifo`

## Requirements
- R1: After reset the level is 0, all flags are 0, every control field is 0, `dac_code_o` is 0 and `irq_o` is 0.
- R2: The register port is word-addressed. Address 0 is control: bits [1:0] format, bit 2 left justify, bit 3 wrap, bit 4 buffer reset, bits 8/9/10 overrun/underrun/went-empty enables. Address 1 is data (write pushes, read gives 0). Address 2 is status: bits [2:0] level, bits 4/5/6 overrun/underrun/went-empty flags. Addresses 3 and 4 are slot readback. Reads are combinational, and a write takes effect at the clock edge that samples it.
- R3: Format 0 and format 3 store one 10-bit sample taken from word bits [9:0].
- R4: Format 1 stores two 10-bit samples, from bits [9:0] first and then from bits [25:16].
- R5: Format 2 stores four 8-bit samples, from byte 0 first up to byte 3 last.
- R6: With left justify clear, a sample sits zero-extended in the low bits of its 16-bit entry. With it set, the sample's MSB sits at entry bit 15 and the low bits are 0.
- R7: An update strobe sampled at a clock edge with the FIFO non-empty (wrap off) loads the oldest entry onto `dac_code_o` at that edge and lowers the level by one.
- R8: A data write needing more entries than are free is dropped whole. It sets the overrun flag, and the level and slot contents stay unchanged.
- R9: An update with level 0 sets the underrun flag, and `dac_code_o` keeps its previous value.
- R10: An update that takes the level from 1 to 0 with wrap off sets the went-empty flag.
- R11: A status write sets each flag to the written bit. A hardware event in the same cycle wins. `irq_o` is high exactly when some flag is set together with its enable.
- R12: With wrap set, updates leave the level unchanged and output entries oldest to newest, then restart at the oldest.
- R13: Writing 1 to control bit 4 empties the FIFO without touching any flag. That bit always reads 0, and the other control fields take the written value.
- R14: Address 3 returns slot 1 in bits [31:16] and slot 0 in bits [15:0], and address 4 does the same for slots 3 and 2. After reset or a buffer reset, the next sample goes to slot 0 and later samples fill the slots in order around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| upd_i | input | 1 | DAC update strobe, one pulse per sample |
| dac_code_o | output | 16 | Registered DAC code |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
Every result lands at the clock edge that samples its stimulus. Register state, level, flags and `dac_code_o` change at that edge, and `irq_o` follows the flags combinationally in the same cycle. The bench drives inputs just after a falling edge and holds them across exactly one rising edge. It then reads the outputs at the next falling edge, so each check sees the state exactly one edge after its stimulus. Expected values come from a queue model of the FIFO kept in the bench, with its own slot ring, replay index and flag bits.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   typedef enum logic [1:0] {
      FMT_ONE_WIDE    = 2'd0,
      FMT_TWO_WIDE    = 2'd1,
      FMT_FOUR_NARROW = 2'd2,
      FMT_SPARE       = 2'd3
   } fmt_e;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] RA_DATA   = 3'd1;
   localparam logic [REG_AW-1:0] RA_STAT   = 3'd2;
   localparam logic [REG_AW-1:0] RA_SLOT01 = 3'd3;
   localparam logic [REG_AW-1:0] RA_SLOT23 = 3'd4;

   // control field positions
   localparam int CB_FMT_LO = 0;
   localparam int CB_LEFT   = 2;
   localparam int CB_WRAP   = 3;
   localparam int CB_FLUSH  = 4;
   localparam int CB_EN_LO  = 8;

   // status flag field
   localparam int SB_FLAG_LO = 4;
   localparam int NFLAG      = 3;
   localparam int FL_OVR     = 0;
   localparam int FL_UND     = 1;
   localparam int FL_EMP     = 2;

endpackage

// File: rtl/dsf_unpack.sv
module dsf_unpack
   import dsf_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int ENTRY_W  = 16,
   parameter int WIDE_W   = 10,
   parameter int NARROW_W = 8,
   parameter int LANES    = 4,
   parameter int CNT_W    = 3
) (
   input  logic [WORD_W-1:0]        word_i,
   input  fmt_e                     fmt_i,
   input  logic                     left_i,
   output logic [LANES*ENTRY_W-1:0] lanes_o,
   output logic [CNT_W-1:0]         count_o
);

   localparam int HALF_W  = WORD_W / 2;
   localparam int PAD_NAR = ENTRY_W - NARROW_W;
   localparam int PAD_WID = ENTRY_W - WIDE_W;

   always_comb begin
      count_o = CNT_W'(1);
      case (fmt_i)
         FMT_TWO_WIDE:    count_o = CNT_W'(2);
         FMT_FOUR_NARROW: count_o = CNT_W'(LANES);
         FMT_ONE_WIDE,
         FMT_SPARE:       count_o = CNT_W'(1);
         default:         count_o = CNT_W'(1);
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [NARROW_W-1:0] nar;
      logic [ENTRY_W-1:0]  nar_j;
      assign nar   = word_i[i*NARROW_W +: NARROW_W];
      assign nar_j = left_i ? {nar, {PAD_NAR{1'b0}}} : {{PAD_NAR{1'b0}}, nar};

      if (i < 2) begin : g_wide
         logic [WIDE_W-1:0]  wid;
         logic [ENTRY_W-1:0] wid_j;
         logic               wid_use;
         assign wid     = word_i[i*HALF_W +: WIDE_W];
         assign wid_j   = left_i ? {wid, {PAD_WID{1'b0}}} : {{PAD_WID{1'b0}}, wid};
         assign wid_use = (i == 0) || (fmt_i == FMT_TWO_WIDE);
         assign lanes_o[i*ENTRY_W +: ENTRY_W] =
            (fmt_i == FMT_FOUR_NARROW) ? nar_j : (wid_use ? wid_j : '0);
      end else begin : g_narrow
         assign lanes_o[i*ENTRY_W +: ENTRY_W] =
            (fmt_i == FMT_FOUR_NARROW) ? nar_j : '0;
      end
   end

endmodule

// File: rtl/dsf_store.sv
module dsf_store #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 16,
   parameter int LANES   = 4,
   parameter int CNT_W   = 3
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     flush_i,
   input  logic                     wr_req_i,
   input  logic [CNT_W-1:0]         wr_n_i,
   input  logic [LANES*ENTRY_W-1:0] wr_lanes_i,
   input  logic                     upd_i,
   input  logic                     wrap_i,
   output logic [CNT_W-1:0]         level_o,
   output logic [ENTRY_W-1:0]       dac_o,
   output logic [DEPTH*ENTRY_W-1:0] slots_o,
   output logic                     ovr_evt_o,
   output logic                     und_evt_o,
   output logic                     drain_evt_o
);

   localparam int PTR_W = $clog2(DEPTH);

   logic [PTR_W-1:0]   hd_q, rep_q, wr_base, rd_idx;
   logic [CNT_W-1:0]   cnt_q, room;
   logic [ENTRY_W-1:0] dac_q;
   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic               no_fit, do_push, upd_eff, take, consume;

   assign room        = CNT_W'(DEPTH) - cnt_q;
   assign no_fit      = wr_n_i > room;
   assign ovr_evt_o   = wr_req_i && !flush_i && no_fit;
   assign do_push     = wr_req_i && !flush_i && !no_fit;
   assign upd_eff     = upd_i && !flush_i;
   assign und_evt_o   = upd_eff && (cnt_q == '0);
   assign take        = upd_eff && (cnt_q != '0);
   assign consume     = take && !wrap_i;
   assign drain_evt_o = consume && (cnt_q == CNT_W'(1)) && !do_push;
   assign wr_base     = hd_q + cnt_q[PTR_W-1:0];
   assign rd_idx      = wrap_i ? hd_q + rep_q : hd_q;

   for (genvar j = 0; j < DEPTH; j++) begin : g_slot
      logic [ENTRY_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q <= '0;
         end else if (do_push) begin
            for (int i = 0; i < LANES; i++) begin
               if ((CNT_W'(i) < wr_n_i) && ((wr_base + PTR_W'(i)) == PTR_W'(j)))
                  q <= wr_lanes_i[i*ENTRY_W +: ENTRY_W];
            end
         end
      end
      assign slot_q[j]                      = q;
      assign slots_o[j*ENTRY_W +: ENTRY_W] = q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hd_q  <= '0;
         rep_q <= '0;
         cnt_q <= '0;
         dac_q <= '0;
      end else if (flush_i) begin
         hd_q  <= '0;
         rep_q <= '0;
         cnt_q <= '0;
      end else begin
         if (take) dac_q <= slot_q[rd_idx];
         if (consume) begin
            hd_q  <= hd_q + PTR_W'(1);
            rep_q <= '0;
         end else if (take) begin
            if (CNT_W'(rep_q) + CNT_W'(1) == cnt_q) rep_q <= '0;
            else                                    rep_q <= rep_q + PTR_W'(1);
         end
         cnt_q <= cnt_q - CNT_W'(consume) + (do_push ? wr_n_i : '0);
      end
   end

   assign level_o = cnt_q;
   assign dac_o   = dac_q;

endmodule

// File: rtl/dsf_flags.sv
module dsf_flags #(
   parameter int N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] evt_i,
   input  logic         wr_i,
   input  logic [N-1:0] wval_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] flags_o,
   output logic         irq_o
);

   for (genvar k = 0; k < N; k++) begin : g_flag
      logic f;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       f <= 1'b0;
         else if (evt_i[k]) f <= 1'b1;
         else if (wr_i)     f <= wval_i[k];
      end
      assign flags_o[k] = f;
   end

   assign irq_o = |(flags_o & en_i);

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
   import dsf_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int ENTRY_W  = 16,
   parameter int DEPTH    = 4,
   parameter int WIDE_W   = 10,
   parameter int NARROW_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [REG_AW-1:0] bus_addr_i,
   input  logic [WORD_W-1:0] bus_wdata_i,
   output logic [WORD_W-1:0] bus_rdata_o,
   input  logic              upd_i,
   output logic [ENTRY_W-1:0] dac_code_o,
   output logic              irq_o
);

   localparam int LANES = WORD_W / NARROW_W;
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin : p_cfg
      assert ($countones(DEPTH) == 1 && DEPTH >= 4)
         else $fatal(1, "DEPTH must be a power of two of at least 4");
      assert (LANES == 4 && LANES * NARROW_W == WORD_W)
         else $fatal(1, "word must hold exactly four narrow samples");
      assert (2 * ENTRY_W == WORD_W)
         else $fatal(1, "slot readback packs two entries per word");
      assert (WIDE_W < ENTRY_W && NARROW_W < ENTRY_W && WIDE_W <= WORD_W / 2)
         else $fatal(1, "sample widths do not fit");
      assert (CNT_W <= SB_FLAG_LO && WORD_W > CB_EN_LO + NFLAG)
         else $fatal(1, "register fields overlap");
   end

   fmt_e               fmt_q;
   logic               left_q, wrap_q;
   logic [NFLAG-1:0]   en_q, flag_q, evt;
   logic               wr_ctrl, wr_dat, wr_stat, flush;
   logic [LANES*ENTRY_W-1:0] lanes;
   logic [CNT_W-1:0]   nsamp, level;
   logic [DEPTH*ENTRY_W-1:0] slots;
   logic               ovr_evt, und_evt, drain_evt;

   assign wr_ctrl = bus_we_i && (bus_addr_i == RA_CTRL);
   assign wr_dat  = bus_we_i && (bus_addr_i == RA_DATA);
   assign wr_stat = bus_we_i && (bus_addr_i == RA_STAT);
   assign flush   = wr_ctrl && bus_wdata_i[CB_FLUSH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fmt_q  <= FMT_ONE_WIDE;
         left_q <= 1'b0;
         wrap_q <= 1'b0;
         en_q   <= '0;
      end else if (wr_ctrl) begin
         fmt_q  <= fmt_e'(bus_wdata_i[CB_FMT_LO +: 2]);
         left_q <= bus_wdata_i[CB_LEFT];
         wrap_q <= bus_wdata_i[CB_WRAP];
         en_q   <= bus_wdata_i[CB_EN_LO +: NFLAG];
      end
   end

   dsf_unpack #(
      .WORD_W(WORD_W), .ENTRY_W(ENTRY_W), .WIDE_W(WIDE_W),
      .NARROW_W(NARROW_W), .LANES(LANES), .CNT_W(CNT_W)
   ) u_unpack (
      .word_i  (bus_wdata_i),
      .fmt_i   (fmt_q),
      .left_i  (left_q),
      .lanes_o (lanes),
      .count_o (nsamp)
   );

   dsf_store #(
      .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LANES(LANES), .CNT_W(CNT_W)
   ) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush),
      .wr_req_i    (wr_dat),
      .wr_n_i      (nsamp),
      .wr_lanes_i  (lanes),
      .upd_i       (upd_i),
      .wrap_i      (wrap_q),
      .level_o     (level),
      .dac_o       (dac_code_o),
      .slots_o     (slots),
      .ovr_evt_o   (ovr_evt),
      .und_evt_o   (und_evt),
      .drain_evt_o (drain_evt)
   );

   always_comb begin
      evt         = '0;
      evt[FL_OVR] = ovr_evt;
      evt[FL_UND] = und_evt;
      evt[FL_EMP] = drain_evt;
   end

   dsf_flags #(.N(NFLAG)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .wr_i    (wr_stat),
      .wval_i  (bus_wdata_i[SB_FLAG_LO +: NFLAG]),
      .en_i    (en_q),
      .flags_o (flag_q),
      .irq_o   (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         RA_CTRL: begin
            bus_rdata_o[CB_FMT_LO +: 2]    = fmt_q;
            bus_rdata_o[CB_LEFT]           = left_q;
            bus_rdata_o[CB_WRAP]           = wrap_q;
            bus_rdata_o[CB_EN_LO +: NFLAG] = en_q;
         end
         RA_STAT: begin
            bus_rdata_o[CNT_W-1:0]           = level;
            bus_rdata_o[SB_FLAG_LO +: NFLAG] = flag_q;
         end
         RA_SLOT01: bus_rdata_o = slots[0 +: 2*ENTRY_W];
         RA_SLOT23: bus_rdata_o = slots[2*ENTRY_W +: 2*ENTRY_W];
         default:   bus_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
   import dsf_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 16,
   parameter int CNT_W   = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               we_i,
   input logic               data_wr_i,
   input logic               flush_i,
   input logic               upd_i,
   input logic               wrap_i,
   input logic [CNT_W-1:0]   level_i,
   input logic [ENTRY_W-1:0] dac_i,
   input logic [NFLAG-1:0]   flags_i,
   input logic [NFLAG-1:0]   en_i,
   input logic               irq_i
);

   a_r1_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_i <= CNT_W'(DEPTH));

   a_r7_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !wrap_i && !we_i && level_i != '0) |=> (level_i == $past(level_i) - CNT_W'(1)));

   a_r8_overrun_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_wr_i && !upd_i && level_i == CNT_W'(DEPTH)) |=> (flags_i[FL_OVR] && $stable(level_i)));

   a_r9_underrun_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !flush_i && level_i == '0) |=> (flags_i[FL_UND] && $stable(dac_i)));

   a_r10_drain_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !wrap_i && !we_i && level_i == CNT_W'(1)) |=> flags_i[FL_EMP]);

   a_r11_irq_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flags_i[FL_OVR]) && en_i[FL_OVR]) |-> irq_i);

   a_r12_wrap_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && wrap_i && !we_i) |=> $stable(level_i));

   a_r13_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (level_i == '0));

endmodule

bind dac_sample_fifo dsf_checker #(
   .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)
) u_dsf_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .we_i      (bus_we_i),
   .data_wr_i (wr_dat),
   .flush_i   (flush),
   .upd_i     (upd_i),
   .wrap_i    (wrap_q),
   .level_i   (level),
   .dac_i     (dac_code_o),
   .flags_i   (flag_q),
   .en_i      (en_q),
   .irq_i     (irq_o)
);

// File: tb/dac_sample_fifo_bench.sv
module dac_sample_fifo_bench;
   import dsf_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wd = '0;
   logic [31:0] rdata;
   logic        upd = 1'b0;
   logic [15:0] dac;
   logic        irq;

   always #10 clk = ~clk;

   dac_sample_fifo u_dac_sample_fifo (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wd), .bus_rdata_o(rdata), .upd_i(upd),
      .dac_code_o(dac), .irq_o(irq)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model
   logic [15:0] q[$];
   logic [15:0] mslot [4];
   int          mhead = 0;
   int          rp = 0;
   bit          mo = 0, mu = 0, me = 0;
   logic [1:0]  mfmt = 2'd0;
   bit          mleft = 0, mwrap = 0;
   logic [2:0]  men = '0;
   logic [15:0] mdac = '0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wd = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   function automatic logic [15:0] j10(logic [9:0] v);
      return mleft ? {v, 6'b0} : {6'b0, v};
   endfunction

   function automatic logic [15:0] j8(logic [7:0] v);
      return mleft ? {v, 8'b0} : {8'b0, v};
   endfunction

   task automatic set_ctrl(logic [1:0] f, bit l, bit w, logic [2:0] e, bit fl);
      logic [31:0] v = '0;
      v[1:0] = f; v[2] = l; v[3] = w; v[4] = fl; v[10:8] = e;
      mfmt = f; mleft = l; mwrap = w; men = e;
      if (fl) begin q.delete(); mhead = 0; rp = 0; end
      wr(RA_CTRL, v);
   endtask

   task automatic push_word(logic [31:0] w);
      logic [15:0] s[$];
      case (mfmt)
         2'd1: begin s.push_back(j10(w[9:0])); s.push_back(j10(w[25:16])); end
         2'd2: for (int k = 0; k < 4; k++) s.push_back(j8(w[8*k +: 8]));
         default: s.push_back(j10(w[9:0]));
      endcase
      if (q.size() + s.size() > 4) mo = 1;
      else foreach (s[k]) begin
         mslot[(mhead + q.size()) % 4] = s[k];
         q.push_back(s[k]);
      end
      wr(RA_DATA, w);
   endtask

   task automatic pop_chk(string req);
      @(negedge clk); upd = 1'b1;
      @(negedge clk); upd = 1'b0;
      if (q.size() == 0) mu = 1;
      else if (mwrap) begin
         mdac = q[rp];
         rp = (rp + 1) % q.size();
      end else begin
         mdac = q.pop_front();
         mhead = (mhead + 1) % 4;
         rp = 0;
         if (q.size() == 0) me = 1;
      end
      check(req, "dac_code", {16'b0, dac}, {16'b0, mdac});
   endtask

   task automatic status_chk(string req);
      logic [31:0] v;
      logic [31:0] e = '0;
      e[2:0] = 3'(q.size()); e[4] = mo; e[5] = mu; e[6] = me;
      rd(RA_STAT, v);
      check(req, "status", v, e);
   endtask

   task automatic irq_chk(string req);
      check(req, "irq", {31'b0, irq}, {31'b0, (mo & men[0]) | (mu & men[1]) | (me & men[2])});
   endtask

   task automatic slots_chk(string req);
      logic [31:0] v;
      rd(RA_SLOT01, v);
      check(req, "slots 1:0", v, {mslot[1], mslot[0]});
      rd(RA_SLOT23, v);
      check(req, "slots 3:2", v, {mslot[3], mslot[2]});
   endtask

   task automatic flags_wr(logic [31:0] v);
      mo = v[4]; mu = v[5]; me = v[6];
      wr(RA_STAT, v);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      logic [31:0] v;
      @(negedge clk);
      rd(RA_CTRL, v);
      check("R1", "ctrl", v, 32'h0);
      status_chk("R1");
      check("R1", "dac_code", {16'b0, dac}, 32'h0);
      check("R1", "irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_single;
      logic [31:0] v;
      set_ctrl(2'd0, 0, 0, 3'b000, 0);
      push_word(32'h1234_F2A5);
      status_chk("R2");
      rd(RA_DATA, v);
      check("R2", "data reads zero", v, 32'h0);
      pop_chk("R3 R7");
      status_chk("R10");
      set_ctrl(2'd3, 1, 0, 3'b000, 0);
      push_word(32'h5555_5C3E);
      pop_chk("R3 R6");
   endtask

   task automatic t_two;
      set_ctrl(2'd1, 1, 0, 3'b000, 0);
      push_word(32'h02C1_8123);
      status_chk("R4");
      pop_chk("R4 R6");
      pop_chk("R4 R6");
   endtask

   task automatic t_four;
      set_ctrl(2'd2, 0, 0, 3'b000, 0);
      push_word(32'h89AB_CDEF);
      status_chk("R5");
      for (int k = 0; k < 4; k++) pop_chk("R5 R7");
   endtask

   task automatic t_overrun;
      flags_wr(32'h0);
      set_ctrl(2'd2, 1, 0, 3'b001, 0);
      push_word(32'h1122_3344);
      slots_chk("R14");
      irq_chk("R11");
      push_word(32'hDEAD_BEEF);
      status_chk("R8");
      slots_chk("R8");
      irq_chk("R11");
   endtask

   task automatic t_drain;
      for (int k = 0; k < 4; k++) pop_chk("R7");
      status_chk("R10");
      pop_chk("R9");
      status_chk("R9");
   endtask

   task automatic t_flags;
      set_ctrl(2'd0, 0, 0, 3'b111, 0);
      flags_wr(32'h70);
      status_chk("R11");
      irq_chk("R11");
      flags_wr(32'h0);
      status_chk("R11");
      irq_chk("R11");
      set_ctrl(2'd0, 0, 0, 3'b010, 0);
      flags_wr(32'h20);
      status_chk("R11");
      irq_chk("R11");
      set_ctrl(2'd0, 0, 0, 3'b101, 0);
      irq_chk("R11");
      flags_wr(32'h0);
   endtask

   task automatic t_partial;
      set_ctrl(2'd0, 0, 0, 3'b000, 0);
      push_word(32'h0000_0101);
      push_word(32'h0000_0202);
      push_word(32'h0000_0303);
      set_ctrl(2'd1, 0, 0, 3'b000, 0);
      push_word(32'h0111_0222);
      status_chk("R8");
      slots_chk("R8");
   endtask

   task automatic t_wrap;
      set_ctrl(2'd0, 0, 1, 3'b000, 0);
      for (int k = 0; k < 7; k++) pop_chk("R12");
      status_chk("R12");
   endtask

   task automatic t_flush;
      logic [31:0] v;
      set_ctrl(2'd2, 1, 1, 3'b110, 1);
      status_chk("R13");
      rd(RA_CTRL, v);
      check("R13", "ctrl after reset bit", v, 32'h0000_060E);
      set_ctrl(2'd0, 0, 0, 3'b000, 0);
      push_word(32'h0000_03C7);
      slots_chk("R14");
      pop_chk("R7");
   endtask

   bit done = 0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_two();
      t_four();
      t_overrun();
      t_drain();
      t_flags();
      t_partial();
      t_wrap();
      t_flush();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule